// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind the receive shifter of an I2C target and decides whether the first byte of a transfer addresses this device. After each START or repeated START, it takes the first complete byte and compares the seven upper bits with a programmable own address. It can also accept the general call address, which is all zeros with a write direction, when that recognition is enabled.

On a hit, the block emits a one-cycle match pulse. It also reports whether the hit was a general call, what the read/write bit was, and whether the target should drive ACK. ACK is driven only when a separate acknowledge-enable control is set. Later bytes of the same transfer never reach the comparator. The comparison keeps running while the host is asleep, and a hit during sleep raises a wake request that stays up until the host wakes.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, matchPulse, isGeneralCall, rwBit, ackDrive and wakeReq are all 0.
- R2: When the first byte after a START has its upper ADDR_W bits equal to ownAddr and is not taken as a general call, matchPulse is 1 for the cycle after the byteValid cycle. In that case isGeneralCall is 0 and rwBit equals bit 0 of the byte (1 = read).
- R3: With gcEnable at 1, a first byte that is entirely zero is a general call match: matchPulse is 1 and isGeneralCall is 1. This takes precedence over an own-address hit.
- R4: A zero address with bit 0 at 1, or a zero byte while gcEnable is 0, is not a general call. Such a byte matches only through the own-address comparison.
- R5: ackDrive becomes ackEnable (as sampled in the byteValid cycle) ANDed with the match result, and holds until the next START. A byte that does not match leaves isGeneralCall, rwBit and ackDrive at 0.
- R6: Bytes after the first in a transfer produce no match pulse and leave isGeneralCall, rwBit and ackDrive unchanged.
- R7: Bytes received before any START are ignored. A byteValid in the same cycle as startDet is ignored, and the byte that follows is treated as the first one.
- R8: matchPulse never stays high for two consecutive cycles.
- R9: wakeReq rises the cycle after a match evaluated while hostSleep is 1. It holds while hostSleep stays 1 and is 0 the cycle after hostSleep was 0.
- R10: One cycle after startDet, isGeneralCall, rwBit and ackDrive are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startDet | input | 1 | One-cycle strobe: START or repeated START seen |
| byteValid | input | 1 | One-cycle strobe: rxByte holds a complete byte |
| rxByte | input | ADDR_W+1 | Received byte, bit 0 = read/write |
| ownAddr | input | ADDR_W | Programmable own address |
| gcEnable | input | 1 | Accept the general call address |
| ackEnable | input | 1 | Allow ACK on a match |
| hostSleep | input | 1 | Host is in a sleep state |
| matchPulse | output | 1 | One-cycle address hit |
| isGeneralCall | output | 1 | Hit was a general call |
| rwBit | output | 1 | Read/write bit of the hit |
| ackDrive | output | 1 | Target should drive ACK |
| wakeReq | output | 1 | Wake request raised by a hit during sleep |

## Verification
The bench builds the block with ADDR_W = 4, so a received byte is five bits wide. At that width it can sweep every own address against every received byte, for every combination of general-call enable, acknowledge enable and sleep. Every address collision is therefore exercised, including an own address of zero against the general call pattern in both directions. The same sweep sends a second byte in each transfer to confirm it is ignored. Separate sequences cover bytes before any START and a START coinciding with a byte.

// File: rtl/i2c_addr_match_pkg.sv
package i2c_addr_match_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAITADDR = 2'd1,
    ST_INXFER   = 2'd2
  } matchState_t;

  typedef struct packed {
    logic clearRes;
    logic evalAddr;
  } ctrlStrobes_t;

endpackage

// File: rtl/i2c_addr_match_ctrl.sv
module i2c_addr_match_ctrl
  import i2c_addr_match_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startDet,
  input  logic         byteValid,
  output ctrlStrobes_t strobes
);

  matchState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    if (startDet) begin
      stateNext        = ST_WAITADDR;
      strobes.clearRes = 1'b1;
    end else begin
      case (state)
        ST_WAITADDR: if (byteValid) begin
          stateNext        = ST_INXFER;
          strobes.evalAddr = 1'b1;
        end
        ST_INXFER: stateNext = ST_INXFER;
        default:   stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R7
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.clearRes, strobes.evalAddr}));

  // R6
  single_eval_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.evalAddr |=> !strobes.evalAddr);

endmodule

// File: rtl/i2c_addr_match_dp.sv
module i2c_addr_match_dp
  import i2c_addr_match_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              gcEnable,
  input  logic              ackEnable,
  input  logic              hostSleep,
  output logic              matchPulse,
  output logic              isGeneralCall,
  output logic              rwBit,
  output logic              ackDrive,
  output logic              wakeReq
);

  logic [ADDR_W-1:0] rxAddr;
  logic              rxRw;
  logic              gcHit, ownHit, anyHit;

  assign rxAddr = rxByte[BYTE_W-1:1];
  assign rxRw   = rxByte[0];
  assign gcHit  = gcEnable && (rxAddr == '0) && !rxRw;
  assign ownHit = (rxAddr == ownAddr);
  assign anyHit = gcHit || ownHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchPulse    <= 1'b0;
      isGeneralCall <= 1'b0;
      rwBit         <= 1'b0;
      ackDrive      <= 1'b0;
    end else begin
      matchPulse <= strobes.evalAddr && anyHit;
      if (strobes.clearRes) begin
        isGeneralCall <= 1'b0;
        rwBit         <= 1'b0;
        ackDrive      <= 1'b0;
      end else if (strobes.evalAddr) begin
        isGeneralCall <= gcHit;
        rwBit         <= anyHit && rxRw;
        ackDrive      <= anyHit && ackEnable;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       wakeReq <= 1'b0;
    else if (strobes.evalAddr && anyHit && hostSleep) wakeReq <= 1'b1;
    else if (!hostSleep)                             wakeReq <= 1'b0;
  end

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> !matchPulse);

  // R3
  gc_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && isGeneralCall) |-> ($past(gcEnable) && $past(rxByte) == '0));

  // R2
  own_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && !isGeneralCall) |->
      ($past(rxByte[BYTE_W-1:1]) == $past(ownAddr) && rwBit == $past(rxByte[0])));

  // R9
  wake_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(hostSleep) |-> !wakeReq);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_addr_match_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startDet,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              gcEnable,
  input  logic              ackEnable,
  input  logic              hostSleep,
  output logic              matchPulse,
  output logic              isGeneralCall,
  output logic              rwBit,
  output logic              ackDrive,
  output logic              wakeReq
);

  ctrlStrobes_t strobes;

  i2c_addr_match_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startDet  (startDet),
    .byteValid (byteValid),
    .strobes   (strobes)
  );

  i2c_addr_match_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .rxByte        (rxByte),
    .ownAddr       (ownAddr),
    .gcEnable      (gcEnable),
    .ackEnable     (ackEnable),
    .hostSleep     (hostSleep),
    .matchPulse    (matchPulse),
    .isGeneralCall (isGeneralCall),
    .rwBit         (rwBit),
    .ackDrive      (ackDrive),
    .wakeReq       (wakeReq)
  );

  // R6
  pulse_needs_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> ($past(byteValid) && !$past(startDet)));

  // R10
  start_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(startDet) |-> (!ackDrive && !isGeneralCall && !rwBit));

  // R5
  ack_needs_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> matchPulse);

endmodule

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;

  localparam int ADDR_W = 4;
  localparam int BYTE_W = ADDR_W + 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startDet = 1'b0;
  logic              byteValid = 1'b0;
  logic [BYTE_W-1:0] rxByte = '0;
  logic [ADDR_W-1:0] ownAddr = '0;
  logic              gcEnable = 1'b0;
  logic              ackEnable = 1'b0;
  logic              hostSleep = 1'b0;
  logic              matchPulse, isGeneralCall, rwBit, ackDrive, wakeReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_addr_match #(.ADDR_W(ADDR_W)) i_i2c_addr_match (
    .clk(clk), .rstN(rstN), .startDet(startDet), .byteValid(byteValid),
    .rxByte(rxByte), .ownAddr(ownAddr), .gcEnable(gcEnable),
    .ackEnable(ackEnable), .hostSleep(hostSleep), .matchPulse(matchPulse),
    .isGeneralCall(isGeneralCall), .rwBit(rwBit), .ackDrive(ackDrive),
    .wakeReq(wakeReq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic doTxn(input int own, input int byteVal, input bit gc, input bit ack, input bit slp);
    int  addr;
    bit  rw, gcHit, hit;
    addr  = byteVal >> 1;
    rw    = byteVal[0];
    gcHit = gc && addr == 0 && !rw;
    hit   = gcHit || addr == own;
    @(negedge clk);
    ownAddr = ADDR_W'(own); gcEnable = gc; ackEnable = ack;
    hostSleep = 1'b0; startDet = 1'b1;
    @(negedge clk);
    startDet = 1'b0;
    chk("R10", "ackDrive after start", ackDrive, 0);
    chk("R10", "isGeneralCall after start", isGeneralCall, 0);
    chk("R10", "rwBit after start", rwBit, 0);
    chk("R9", "wakeReq after awake cycle", wakeReq, 0);
    rxByte = BYTE_W'(byteVal); byteValid = 1'b1; hostSleep = slp;
    @(negedge clk);
    byteValid = 1'b0;
    chk(gcHit ? "R3" : (addr == 0 ? "R4" : "R2"), "matchPulse", matchPulse, int'(hit));
    chk("R3", "isGeneralCall", isGeneralCall, int'(gcHit));
    chk("R2", "rwBit", rwBit, int'(hit && rw));
    chk("R5", "ackDrive", ackDrive, int'(hit && ack));
    chk("R9", "wakeReq", wakeReq, int'(hit && slp));
    @(negedge clk);
    chk("R8", "matchPulse second cycle", matchPulse, 0);
    byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
    chk("R6", "matchPulse on later byte", matchPulse, 0);
    chk("R6", "isGeneralCall held", isGeneralCall, int'(gcHit));
    chk("R6", "rwBit held", rwBit, int'(hit && rw));
    chk("R6", "ackDrive held", ackDrive, int'(hit && ack));
    chk("R9", "wakeReq held in sleep", wakeReq, int'(hit && slp));
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "matchPulse in reset", matchPulse, 0);
    chk("R1", "wakeReq in reset", wakeReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "isGeneralCall after reset", isGeneralCall, 0);
    chk("R1", "rwBit after reset", rwBit, 0);
    chk("R1", "ackDrive after reset", ackDrive, 0);

    // R7: byte before any start, with a matching address
    ownAddr = 4'd5; ackEnable = 1'b1; hostSleep = 1'b1;
    rxByte = BYTE_W'(5 << 1); byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
    chk("R7", "matchPulse before start", matchPulse, 0);
    chk("R7", "ackDrive before start", ackDrive, 0);
    chk("R7", "wakeReq before start", wakeReq, 0);
    hostSleep = 1'b0;

    // R7: start and byte in the same cycle, then a real first byte
    startDet = 1'b1; byteValid = 1'b1;
    @(negedge clk);
    startDet = 1'b0; byteValid = 1'b0;
    chk("R7", "matchPulse start+byte", matchPulse, 0);
    byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
    chk("R7", "matchPulse first byte after start", matchPulse, 1);
    chk("R7", "ackDrive first byte after start", ackDrive, 1);

    // R9: wake release
    @(negedge clk);
    startDet = 1'b1; hostSleep = 1'b0;
    @(negedge clk);
    startDet = 1'b0; byteValid = 1'b1; hostSleep = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
    chk("R9", "wakeReq raised", wakeReq, 1);
    hostSleep = 1'b0;
    @(negedge clk);
    chk("R9", "wakeReq released", wakeReq, 0);

    for (int own = 0; own < (1 << ADDR_W); own++)
      for (int b = 0; b < (1 << BYTE_W); b++)
        for (int cfg = 0; cfg < 8; cfg++)
          doTxn(own, b, cfg[0], cfg[1], cfg[2]);

    finishRun();
  end

endmodule